// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block sits in front of a pipelined synchronous memory and turns one captured starting address into the four addresses of a burst. On a rising clock edge where either of two active-low address strobes is low, it latches the external address and the chip-select. One strobe serves the processor side and the other serves a memory controller. After the load, each cycle with the active-low advance input low steps a 2-bit beat counter. The counter supplies the low two address bits, so a burst follows the 3-1-1-1 pattern: one initial access, then three single-cycle beats.

A static, asynchronous ordering input chooses how the beat index maps onto the low address bits. In interleaved order the low bits are the starting low bits XOR the beat. In linear order they are the starting low bits plus the beat, modulo 4. The upper address bits never change during a burst. When advance stays low, the counter wraps and the burst keeps cycling inside the same group of four addresses. The chip-select is registered along with the address, so it goes through the same pipeline stage as the address.

All pins are plain control and status pins. There is no streaming data path and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `mem_addr` is 0, `selected` is 0 and `beat_idx` is 0.
- R2: A rising edge with `proc_strobe_n` low or `ctrl_strobe_n` low loads `ext_addr` into `mem_addr` and `ext_cs` into `selected`, and clears `beat_idx` to 0. The new values are visible after that edge.
- R3: A rising edge with both strobes high and `advance_n` low adds 1 to `beat_idx`, modulo 4 (3 is followed by 0).
- R4: With `linear_order` = 0 (interleaved), `mem_addr[1:0]` equals the loaded low bits XOR `beat_idx`.
- R5: With `linear_order` = 1 (linear), `mem_addr[1:0]` equals (loaded low bits + `beat_idx`) mod 4.
- R6: During advances, `mem_addr[AW-1:2]` keeps its loaded value. After four advances, `mem_addr` is back at the starting address.
- R7: A rising edge with both strobes and `advance_n` high leaves `mem_addr`, `selected` and `beat_idx` unchanged.
- R8: When both strobes are low in the same cycle, the processor strobe takes priority. The result is identical to a load by one strobe alone, and `advance_n` is ignored.
- R9: `linear_order` acts without a clock edge: changing it changes `mem_addr[1:0]` at once, according to R4/R5, and leaves `beat_idx` unchanged.
- R10: `ext_cs` and `ext_addr` have no effect on any output unless a strobe is low at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| ext_cs | input | 1 | Chip-select captured with the address |
| ext_addr | input | AW | External starting address |
| linear_order | input | 1 | 1 = linear order, 0 = interleaved order; static |
| mem_addr | output | AW | Current internal burst address |
| selected | output | 1 | Registered chip-select |
| beat_idx | output | 2 | Current beat number, 0 to 3 |

## Verification
The step properties assume that `linear_order` does not change between two consecutive edges. When it does change, they excuse that cycle instead of predicting a mixed result. The stimulus changes the ordering input only while strobes and advance are idle. Inputs are driven only at falling edges, so every strobe and advance value is settled at the rising edge that samples it. The ordering input is toggled in one scenario only, and that scenario exercises the combinational path of R9.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    OP_HOLD      = 2'd0,
    OP_LOAD_PROC = 2'd1,
    OP_LOAD_CTRL = 2'd2,
    OP_STEP      = 2'd3
  } burst_op_e;

  localparam int unsigned BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] map_low_bits(
    input logic [BEAT_W-1:0] start_bits,
    input logic [BEAT_W-1:0] beat,
    input logic              linear
  );
    logic [BEAT_W-1:0] r;
    if (linear) r = start_bits + beat;
    else        r = start_bits ^ beat;
    return r;
  endfunction

  function automatic logic op_is_load(input burst_op_e op);
    return (op == OP_LOAD_PROC) || (op == OP_LOAD_CTRL);
  endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_pkg::*;
(
  input  logic      proc_n,
  input  logic      ctrl_n,
  input  logic      adv_n,
  output burst_op_e op
);
  always_comb begin
    if (!proc_n)      op = OP_LOAD_PROC;
    else if (!ctrl_n) op = OP_LOAD_CTRL;
    else if (!adv_n)  op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  burst_op_e         op,
  output logic [BEAT_W-1:0] beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              beat <= '0;
    else if (op_is_load(op)) beat <= '0;
    else if (op == OP_STEP)  beat <= beat + 1'b1;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_op_e     op,
  input  logic [AW-1:0] addr_d,
  input  logic          cs_d,
  output logic [AW-1:0] base_q,
  output logic          cs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cs_q   <= 1'b0;
    end else if (op_is_load(op)) begin
      base_q <= addr_d;
      cs_q   <= cs_d;
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proc_strobe_n,
  input  logic          ctrl_strobe_n,
  input  logic          advance_n,
  input  logic          ext_cs,
  input  logic [AW-1:0] ext_addr,
  input  logic          linear_order,
  output logic [AW-1:0] mem_addr,
  output logic          selected,
  output logic [1:0]    beat_idx
);
  localparam int unsigned HI_W = AW - BEAT_W;

  burst_op_e         op;
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;

  burst_op_decode u_dec (
    .proc_n (proc_strobe_n),
    .ctrl_n (ctrl_strobe_n),
    .adv_n  (advance_n),
    .op     (op)
  );

  burst_beat_counter u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .beat (beat_q)
  );

  burst_base_reg #(.AW(AW)) u_base (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .addr_d(ext_addr),
    .cs_d  (ext_cs),
    .base_q(base_q),
    .cs_q  (selected)
  );

  generate
    if (HI_W > 0) begin : g_hi
      assign mem_addr[AW-1:BEAT_W] = base_q[AW-1:BEAT_W];
    end
  endgenerate

  assign mem_addr[BEAT_W-1:0] = map_low_bits(base_q[BEAT_W-1:0], beat_q, linear_order);
  assign beat_idx = beat_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          proc_strobe_n,
  input logic          ctrl_strobe_n,
  input logic          advance_n,
  input logic          ext_cs,
  input logic [AW-1:0] ext_addr,
  input logic          linear_order,
  input logic [AW-1:0] mem_addr,
  input logic          selected,
  input logic [1:0]    beat_idx
);
  logic load_c, step_c, idle_c;
  assign load_c = !proc_strobe_n || !ctrl_strobe_n;
  assign step_c = proc_strobe_n && ctrl_strobe_n && !advance_n;
  assign idle_c = proc_strobe_n && ctrl_strobe_n && advance_n;

  // R2, R8: load captures address and chip-select, clears the beat
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_c |=> (mem_addr == $past(ext_addr)) && (selected == $past(ext_cs)) && (beat_idx == 2'd0));

  // R3: advance increments the beat modulo 4
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_c |=> beat_idx == 2'($past(beat_idx) + 2'd1));

  // R5: linear order steps the low address bits by one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_c && linear_order) |=> (!linear_order || mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1)));

  // R4: interleaved order flips low bits exactly as the beat changes
  a_r4_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_c && !linear_order) |=> (linear_order ||
      (mem_addr[1:0] ^ $past(mem_addr[1:0])) == (beat_idx ^ $past(beat_idx))));

  // R6: upper bits and chip-select hold through advances
  a_r6_group: assert property (@(posedge clk) disable iff (!rst_n)
    step_c |=> $stable(mem_addr[AW-1:2]) && $stable(selected));

  // R7, R10: idle cycles change nothing registered
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle_c |=> $stable(beat_idx) && $stable(selected) && $stable(mem_addr[AW-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
  .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .ext_cs(ext_cs),
  .ext_addr(ext_addr), .linear_order(linear_order), .mem_addr(mem_addr),
  .selected(selected), .beat_idx(beat_idx)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int CLK_P = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proc_strobe_n = 1'b1;
  logic          ctrl_strobe_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          ext_cs = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          linear_order = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          selected;
  logic [1:0]    beat_idx;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .proc_strobe_n(proc_strobe_n),
    .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .ext_cs(ext_cs),
    .ext_addr(ext_addr), .linear_order(linear_order), .mem_addr(mem_addr),
    .selected(selected), .beat_idx(beat_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic lin);
    return lin ? 2'(s + b) : (s ^ b);
  endfunction

  // one clock: inputs set at falling edge, outputs sampled at the next falling edge
  task automatic cycle(input logic p, input logic c, input logic a);
    @(negedge clk);
    proc_strobe_n = p; ctrl_strobe_n = c; advance_n = a;
    @(negedge clk);
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
  endtask

  task automatic load(input logic use_proc, input logic [AW-1:0] a, input logic cs);
    @(negedge clk);
    ext_addr = a; ext_cs = cs;
    proc_strobe_n = !use_proc; ctrl_strobe_n = use_proc; advance_n = 1'b1;
    @(negedge clk);
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 addr", mem_addr, 0);
    check("R1 sel", selected, 0);
    check("R1 beat", beat_idx, 0);
  endtask

  task automatic run_burst(input string req, input logic [AW-1:0] a, input logic lin);
    linear_order = lin;
    load(1'b1, a, 1'b1);
    check("R2 load addr", mem_addr, a);
    check("R2 load beat", beat_idx, 0);
    for (int k = 1; k <= 5; k++) begin
      cycle(1'b1, 1'b1, 1'b0);
      check("R3 beat", beat_idx, k % 4);
      check(req, mem_addr, {a[AW-1:2], exp_low(a[1:0], 2'(k), lin)});
      check("R6 upper", mem_addr[AW-1:2], a[AW-1:2]);
    end
  endtask

  task automatic t_ctrl_load();
    linear_order = 1'b1;
    load(1'b0, 8'hC6, 1'b0);
    check("R2 ctrl addr", mem_addr, 8'hC6);
    check("R2 ctrl sel", selected, 0);
    load(1'b0, 8'h31, 1'b1);
    check("R2 ctrl sel set", selected, 1);
  endtask

  task automatic t_hold();
    linear_order = 1'b0;
    load(1'b1, 8'h5B, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      ext_cs = k[0]; ext_addr = 8'(8'hA0 + k);
      @(negedge clk);
      check("R7 hold addr", mem_addr, 8'h5A);
      check("R7 hold beat", beat_idx, 1);
      check("R10 cs ignored", selected, 1);
    end
  endtask

  task automatic t_both();
    linear_order = 1'b0;
    @(negedge clk);
    ext_addr = 8'h77; ext_cs = 1'b1;
    proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; advance_n = 1'b0;
    @(negedge clk);
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
    check("R8 both addr", mem_addr, 8'h77);
    check("R8 both beat", beat_idx, 0);
    check("R8 both sel", selected, 1);
  endtask

  task automatic t_mode_flip();
    linear_order = 1'b0;
    load(1'b1, 8'h41, 1'b1);
    cycle(1'b1, 1'b1, 1'b0);
    check("R4 interleave", mem_addr, 8'h40);
    #1 linear_order = 1'b1;
    #1 check("R9 linear now", mem_addr, 8'h42);
    check("R9 beat kept", beat_idx, 1);
    #1 linear_order = 1'b0;
    #1 check("R9 back", mem_addr, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_burst("R4 interleave", 8'h5B, 1'b0);
    run_burst("R5 linear", 8'h9E, 1'b1);
    for (int s = 0; s < 4; s++) begin
      run_burst("R4 interleave sweep", 8'(8'h10 + s), 1'b0);
      run_burst("R5 linear sweep", 8'(8'hF0 + s), 1'b1);
    end
    t_ctrl_load();
    t_hold();
    t_both();
    t_mode_flip();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule